// File: doc/BRIEF.md
# Regulator Power-Good and Fault Supervisor

This block sequences a step-down regulator and protects it. It takes digitised comparator flags (overvoltage, undervoltage, output below half of target, current limit, over-temperature trip and its cool-down release), the soft-start-done and output-slewing flags, the enable input and a switching-clock tick. From these it drives the run command, a soft-start restart pulse, the open-drain power-good pull-down, and one-cycle event pulses for overvoltage, undervoltage, overcurrent and thermal shutdown.

The sequencer moves through six states: idle, enable delay, soft-start, regulating, hiccup-off and thermal-off. An overvoltage or undervoltage flag counts only after it has persisted for a qualification time. Slewing of the output code blanks both checks. Power-good is released only after the output has stayed inside its window for a full timeout while regulating. A short circuit after soft-start causes a timed hiccup, after which soft-start is repeated. All time counts are in switching-clock ticks.

Top module: `vreg_supervisor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `run` is 0, `pg_pull_low` is 1 and every event output is 0.
- R2: An overvoltage or undervoltage flag becomes qualified only after `QUAL_TICKS` ticks of continuous assertion. A shorter excursion changes no output.
- R3: `pg_pull_low` is 0 only in the regulating state, and only once `PG_DELAY` ticks have passed with neither qualified flag set. A qualified flag pulls it to 1 on the next cycle and restarts the count.
- R4: While `slewing` is 1, both qualifiers are held cleared, so no event is raised and power-good is not disturbed.
- R5: `ev_ov` or `ev_uv` is a single-cycle pulse in the first cycle the corresponding flag is qualified.
- R6: `run` is 1 exactly in the soft-start and regulating states.
- R7: With `en` high, soft-start is entered after `EN_DLY` ticks in the enable delay. Every entry to soft-start raises a single-cycle `ss_start` pulse.
- R8: In the regulating state, `below_half` and `ilim` together enter hiccup-off and raise a single-cycle `ev_oc`. The state then waits `HICCUP_TICKS` ticks before re-entering soft-start. The same condition during soft-start is ignored.
- R9: `ot_trip` in any active state enters thermal-off with a single-cycle `ev_ot`. This takes priority over the hiccup condition in the same cycle. Leaving thermal-off needs `ot_clear`, and the exit leads to the enable delay.
- R10: `en` low returns the sequencer to idle on the next clock from any state, with priority over every other condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle switching-clock tick |
| en | input | 1 | Regulator enable |
| ov_raw | input | 1 | Output above overvoltage threshold |
| uv_raw | input | 1 | Output below undervoltage threshold |
| below_half | input | 1 | Output below half of target |
| ilim | input | 1 | Current limit active |
| ot_trip | input | 1 | Over-temperature trip |
| ot_clear | input | 1 | Die has cooled by the hysteresis amount |
| slewing | input | 1 | Output target is slewing |
| ss_done | input | 1 | Soft-start ramp complete |
| pg_pull_low | output | 1 | 1 = pull power-good pin low |
| run | output | 1 | Power stage run command |
| ss_start | output | 1 | Pulse: start a soft-start ramp |
| ev_ov | output | 1 | Pulse: overvoltage qualified |
| ev_uv | output | 1 | Pulse: undervoltage qualified |
| ev_oc | output | 1 | Pulse: hiccup entered |
| ev_ot | output | 1 | Pulse: thermal shutdown entered |

## Verification
The thermal trip and the short-circuit hiccup condition can arrive in the same cycle while regulating. Both are only meaningful after soft-start, and each has its own event pulse. The bench raises `ot_trip`, `below_half` and `ilim` on the same edge. It then expects a thermal event and no overcurrent event, and the run command must stay off until the release flag arrives. A second collision, a qualifier expiring while `slewing` rises, is reached during a long random phase. There a behavioural reference model judges every output on every clock.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EDLY  = 3'd1,
        ST_SOFT  = 3'd2,
        ST_REG   = 3'd3,
        ST_HICC  = 3'd4,
        ST_THERM = 3'd5
    } sup_state_e;
endpackage

// File: rtl/sup_qualifier.sv
module sup_qualifier #(
    parameter int QUAL_TICKS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    input  logic blank,
    output logic qual,
    output logic event_pulse
);
    localparam int CW = $clog2(QUAL_TICKS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          q;
        logic          ev;
    } qreg_t;

    qreg_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.ev = 1'b0;
        if (!raw || blank) begin
            r_d.cnt = '0;
            r_d.q   = 1'b0;
        end else if (tick && !r_q.q) begin
            if (r_q.cnt == CW'(QUAL_TICKS - 1)) begin
                r_d.q  = 1'b1;
                r_d.ev = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign qual        = r_q.q;
    assign event_pulse = r_q.ev;

    p_blank_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> !qual);
    p_event_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> (qual && !$past(qual)));
    p_needs_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !raw |=> !qual);
endmodule

// File: rtl/sup_pg_timer.sv
module sup_pg_timer #(
    parameter int PG_DELAY = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic in_reg,
    input  logic window_bad,
    output logic released
);
    localparam int PW = $clog2(PG_DELAY + 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!in_reg || window_bad)
            cnt_d = '0;
        else if (tick && cnt_q != PW'(PG_DELAY))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign released = (cnt_q == PW'(PG_DELAY));

    p_window_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (window_bad || !in_reg) |=> !released);
endmodule

// File: rtl/sup_sequencer.sv
module sup_sequencer
    import sup_pkg::*;
#(
    parameter int EN_DLY       = 308,
    parameter int HICCUP_TICKS = 8800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       ot_trip,
    input  logic       ot_clear,
    input  logic       ss_done,
    input  logic       below_half,
    input  logic       ilim,
    output sup_state_e state,
    output logic       run,
    output logic       ss_start,
    output logic       ev_oc,
    output logic       ev_ot
);
    localparam int MAXC = (EN_DLY > HICCUP_TICKS) ? EN_DLY : HICCUP_TICKS;
    localparam int TW   = $clog2(MAXC + 1);

    typedef struct packed {
        sup_state_e    st;
        logic [TW-1:0] tmr;
        logic          ss;
        logic          oc;
        logic          ot;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ss = 1'b0;
        s_d.oc = 1'b0;
        s_d.ot = 1'b0;
        if (!en) begin
            s_d.st  = ST_IDLE;
            s_d.tmr = '0;
        end else begin
            unique case (s_q.st)
                ST_IDLE: begin
                    s_d.st  = ST_EDLY;
                    s_d.tmr = '0;
                end
                ST_EDLY: begin
                    if (ot_trip) begin
                        s_d.st = ST_THERM;
                        s_d.ot = 1'b1;
                    end else if (tick) begin
                        if (s_q.tmr == TW'(EN_DLY - 1)) begin
                            s_d.st  = ST_SOFT;
                            s_d.tmr = '0;
                            s_d.ss  = 1'b1;
                        end else begin
                            s_d.tmr = s_q.tmr + 1'b1;
                        end
                    end
                end
                ST_SOFT: begin
                    if (ot_trip) begin
                        s_d.st = ST_THERM;
                        s_d.ot = 1'b1;
                    end else if (ss_done) begin
                        s_d.st = ST_REG;
                    end
                end
                ST_REG: begin
                    if (ot_trip) begin
                        s_d.st = ST_THERM;
                        s_d.ot = 1'b1;
                    end else if (below_half && ilim) begin
                        s_d.st  = ST_HICC;
                        s_d.tmr = '0;
                        s_d.oc  = 1'b1;
                    end
                end
                ST_HICC: begin
                    if (ot_trip) begin
                        s_d.st = ST_THERM;
                        s_d.ot = 1'b1;
                    end else if (tick) begin
                        if (s_q.tmr == TW'(HICCUP_TICKS - 1)) begin
                            s_d.st  = ST_SOFT;
                            s_d.tmr = '0;
                            s_d.ss  = 1'b1;
                        end else begin
                            s_d.tmr = s_q.tmr + 1'b1;
                        end
                    end
                end
                ST_THERM: begin
                    if (ot_clear) begin
                        s_d.st  = ST_EDLY;
                        s_d.tmr = '0;
                    end
                end
                default: begin
                    s_d.st  = ST_IDLE;
                    s_d.tmr = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign state    = s_q.st;
    assign run      = (s_q.st == ST_SOFT) || (s_q.st == ST_REG);
    assign ss_start = s_q.ss;
    assign ev_oc    = s_q.oc;
    assign ev_ot    = s_q.ot;

    p_en_low_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE));
    p_hiccup_from_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_oc |-> (state == ST_HICC && $past(state) == ST_REG));
    p_thermal_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ot |-> (!run && state == ST_THERM));
    p_restart_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start |-> (state == ST_SOFT && $past(state) != ST_SOFT));
endmodule

// File: rtl/vreg_supervisor.sv
module vreg_supervisor
    import sup_pkg::*;
#(
    parameter int QUAL_TICKS   = 11,
    parameter int PG_DELAY     = 256,
    parameter int EN_DLY       = 308,
    parameter int HICCUP_TICKS = 8800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic ov_raw,
    input  logic uv_raw,
    input  logic below_half,
    input  logic ilim,
    input  logic ot_trip,
    input  logic ot_clear,
    input  logic slewing,
    input  logic ss_done,
    output logic pg_pull_low,
    output logic run,
    output logic ss_start,
    output logic ev_ov,
    output logic ev_uv,
    output logic ev_oc,
    output logic ev_ot
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_v, qual_v, ev_v;
    sup_state_e     state;
    logic           pg_ok;

    assign raw_v = {uv_raw, ov_raw};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        sup_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .raw        (raw_v[g]),
            .blank      (slewing),
            .qual       (qual_v[g]),
            .event_pulse(ev_v[g])
        );
    end

    sup_sequencer #(.EN_DLY(EN_DLY), .HICCUP_TICKS(HICCUP_TICKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .en        (en),
        .ot_trip   (ot_trip),
        .ot_clear  (ot_clear),
        .ss_done   (ss_done),
        .below_half(below_half),
        .ilim      (ilim),
        .state     (state),
        .run       (run),
        .ss_start  (ss_start),
        .ev_oc     (ev_oc),
        .ev_ot     (ev_ot)
    );

    sup_pg_timer #(.PG_DELAY(PG_DELAY)) u_pg (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .in_reg    (state == ST_REG),
        .window_bad(|qual_v),
        .released  (pg_ok)
    );

    assign pg_pull_low = !(pg_ok && state == ST_REG);
    assign ev_ov       = ev_v[0];
    assign ev_uv       = ev_v[1];

    p_pg_only_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_pull_low |-> run);
    p_pg_drops_on_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ov || ev_uv) |=> pg_pull_low);
endmodule

// File: tb/test_vreg_supervisor.sv
module test_vreg_supervisor;
    localparam int QT  = 3;
    localparam int PGD = 8;
    localparam int EDL = 4;
    localparam int HIC = 20;

    localparam int M_IDLE = 0, M_EDLY = 1, M_SOFT = 2, M_REG = 3, M_HICC = 4, M_THERM = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, en = 1'b0, ov_raw = 1'b0, uv_raw = 1'b0, below_half = 1'b0, ilim = 1'b0;
    logic ot_trip = 1'b0, ot_clear = 1'b0, slewing = 1'b0, ss_done = 1'b0;
    logic pg_pull_low, run, ss_start, ev_ov, ev_uv, ev_oc, ev_ot;

    always #4 clk = ~clk;

    vreg_supervisor #(.QUAL_TICKS(QT), .PG_DELAY(PGD), .EN_DLY(EDL), .HICCUP_TICKS(HIC)) i_vreg_supervisor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .ov_raw(ov_raw), .uv_raw(uv_raw),
        .below_half(below_half), .ilim(ilim), .ot_trip(ot_trip), .ot_clear(ot_clear),
        .slewing(slewing), .ss_done(ss_done), .pg_pull_low(pg_pull_low), .run(run),
        .ss_start(ss_start), .ev_ov(ev_ov), .ev_uv(ev_uv), .ev_oc(ev_oc), .ev_ot(ev_ot)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit rnd_phase = 1'b0;
    bit seen_ov = 0, seen_uv = 0, seen_oc = 0, seen_ot = 0, seen_ss = 0;

    // behavioural reference model
    int m_st = M_IDLE, m_tm = 0, m_pgc = 0;
    int m_qc[2] = '{0, 0};
    bit m_q[2]  = '{0, 0};
    bit m_ev[2] = '{0, 0};
    bit m_ss = 0, m_oc = 0, m_ot = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_tm = 0; m_pgc = 0;
            m_qc = '{0, 0}; m_q = '{0, 0}; m_ev = '{0, 0};
            m_ss = 0; m_oc = 0; m_ot = 0;
        end else begin
            if (m_st != M_REG || m_q[0] || m_q[1]) m_pgc = 0;
            else if (tick && m_pgc < PGD) m_pgc++;
            for (int ch = 0; ch < 2; ch++) begin
                bit r, nq;
                r  = (ch == 0) ? ov_raw : uv_raw;
                nq = m_q[ch];
                if (!r || slewing) begin m_qc[ch] = 0; nq = 0; end
                else if (tick && !m_q[ch]) begin
                    m_qc[ch]++;
                    if (m_qc[ch] >= QT) nq = 1;
                end
                m_ev[ch] = nq && !m_q[ch];
                m_q[ch]  = nq;
            end
            m_ss = 0; m_oc = 0; m_ot = 0;
            if (!en) begin m_st = M_IDLE; m_tm = 0; end
            else if (m_st == M_IDLE) begin m_st = M_EDLY; m_tm = 0; end
            else if (m_st == M_THERM) begin
                if (ot_clear) begin m_st = M_EDLY; m_tm = 0; end
            end else if (ot_trip) begin m_st = M_THERM; m_ot = 1; end
            else if (m_st == M_EDLY || m_st == M_HICC) begin
                if (tick) begin
                    m_tm++;
                    if (m_tm == ((m_st == M_EDLY) ? EDL : HIC)) begin m_st = M_SOFT; m_tm = 0; m_ss = 1; end
                end
            end else if (m_st == M_SOFT) begin
                if (ss_done) m_st = M_REG;
            end else if (m_st == M_REG && below_half && ilim) begin
                m_st = M_HICC; m_tm = 0; m_oc = 1;
            end
        end
    end

    task automatic cmp(string tag, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, nm, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        cmp("R3", "pg_pull_low", pg_pull_low, !(m_st == M_REG && m_pgc == PGD));
        cmp("R6", "run", run, (m_st == M_SOFT || m_st == M_REG));
        cmp("R7", "ss_start", ss_start, m_ss);
        cmp("R5", "ev_ov", ev_ov, m_ev[0]);
        cmp("R5", "ev_uv", ev_uv, m_ev[1]);
        cmp("R8", "ev_oc", ev_oc, m_oc);
        cmp("R9", "ev_ot", ev_ot, m_ot);
        if (ev_ov) seen_ov = 1;
        if (ev_uv) seen_uv = 1;
        if (ev_oc) seen_oc = 1;
        if (ev_ot) seen_ot = 1;
        if (ss_start) seen_ss = 1;
        if (rnd_phase) begin
            tick = $urandom % 2;
            if ($urandom % 8 == 0)  ov_raw = ~ov_raw;
            if ($urandom % 8 == 0)  uv_raw = ~uv_raw;
            if ($urandom % 16 == 0) slewing = ~slewing;
            if ($urandom % 10 == 0) below_half = ~below_half;
            if ($urandom % 10 == 0) ilim = ~ilim;
            ot_trip  = ($urandom % 150 == 0);
            ot_clear = ($urandom % 16 == 0);
            ss_done  = ($urandom % 8 == 0);
            en       = ($urandom % 120 != 0);
        end else begin
            tick = (cyc % 4 != 3);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_seen();
        seen_ov = 0; seen_uv = 0; seen_oc = 0; seen_ot = 0; seen_ss = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        cmp("R1", "pg_pull_low in reset", pg_pull_low, 1'b1);
        cmp("R1", "run in reset", run, 1'b0);
        cmp("R1", "events in reset", ev_ov | ev_uv | ev_oc | ev_ot | ss_start, 1'b0);
        rst_n = 1'b1;
        step(1);
        cmp("R1", "run after reset", run, 1'b0);

        en = 1'b1; clr_seen();
        step(12);
        cmp("R7", "run after enable delay", run, 1'b1);
        cmp("R7", "soft-start pulse seen", seen_ss, 1'b1);
        ss_done = 1'b1; step(1); ss_done = 1'b0;
        step(16);
        cmp("R3", "power-good released", pg_pull_low, 1'b0);

        clr_seen();
        ov_raw = 1'b1; step(2); ov_raw = 1'b0; step(2);
        cmp("R2", "short excursion pg", pg_pull_low, 1'b0);
        cmp("R2", "short excursion event", seen_ov, 1'b0);

        ov_raw = 1'b1; step(8);
        cmp("R5", "ov event", seen_ov, 1'b1);
        cmp("R3", "pg low on ov", pg_pull_low, 1'b1);
        ov_raw = 1'b0; step(16);
        cmp("R3", "pg back after window", pg_pull_low, 1'b0);

        clr_seen();
        slewing = 1'b1; uv_raw = 1'b1; step(20);
        cmp("R4", "uv blanked event", seen_uv, 1'b0);
        cmp("R4", "uv blanked pg", pg_pull_low, 1'b0);
        slewing = 1'b0; step(8);
        cmp("R5", "uv event after blank", seen_uv, 1'b1);
        uv_raw = 1'b0; step(16);

        clr_seen();
        below_half = 1'b1; ilim = 1'b1; step(2);
        cmp("R8", "hiccup event", seen_oc, 1'b1);
        cmp("R6", "run off in hiccup", run, 1'b0);
        below_half = 1'b0; ilim = 1'b0;
        step(34);
        cmp("R8", "soft-start repeated", run, 1'b1);
        cmp("R7", "restart pulse", seen_ss, 1'b1);

        clr_seen();
        below_half = 1'b1; ilim = 1'b1; step(5);
        cmp("R8", "no hiccup in soft-start", seen_oc, 1'b0);
        below_half = 1'b0; ilim = 1'b0;
        ss_done = 1'b1; step(1); ss_done = 1'b0; step(3);

        clr_seen();
        ot_trip = 1'b1; below_half = 1'b1; ilim = 1'b1; step(1);
        ot_trip = 1'b0; below_half = 1'b0; ilim = 1'b0; step(1);
        cmp("R9", "thermal event on collision", seen_ot, 1'b1);
        cmp("R9", "no hiccup on collision", seen_oc, 1'b0);
        step(20);
        cmp("R9", "held off until release", run, 1'b0);
        ot_clear = 1'b1; step(1); ot_clear = 1'b0; step(12);
        cmp("R9", "restart after release", run, 1'b1);

        en = 1'b0; step(1);
        cmp("R10", "enable low stops", run, 1'b0);
        en = 1'b1; step(4);

        rnd_phase = 1'b1;
        step(6000);
        rnd_phase = 1'b0;
        en = 1'b0; step(2);
        cmp("R10", "final disable", run, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule